// File: doc/BRIEF.md
# Dual gated-edge one-shot pulse generator

This block produces fixed-length pulses from asynchronous trigger inputs, in the manner of a monostable that cannot be retriggered and that has an overriding clear. Each channel has a falling-edge trigger input, a rising-edge trigger input, an active-low clear and a pair of complementary outputs. The pulse length is a count of clock cycles taken from a per-channel width input at the moment of triggering. An external resistor and capacitor would otherwise set that length.

Every asynchronous input passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one clock earlier. A pulse starts in one of three ways: the falling trigger drops while the rising trigger is high, the rising trigger climbs while the falling trigger is low, or clear is released after an arming sequence. While a pulse runs, further trigger activity is ignored. Pulling clear low ends the pulse at once. The channels share only the clock and reset.

Top module: `oneshot_pair`

## Requirements
- R1: With clear high and the rising trigger high, a high-to-low change on the falling trigger starts one pulse. Q goes high after the third clock edge that samples the new level.
- R2: With clear high and the falling trigger low, a low-to-high change on the rising trigger starts one pulse, with the same three-edge latency.
- R3: Q stays high for exactly W cycles, where W is the channel's width input sampled when the trigger is taken (width bits `[ch*WIDTH +: WIDTH]`).
- R4: A trigger taken with W = 0 produces no pulse.
- R5: While a pulse runs, trigger edges of any kind do not lengthen, restart or queue a pulse. After the pulse ends, Q stays low until a new qualifying edge arrives.
- R6: While the synchronised clear is low, Q is low and Qn high. Lowering clear during a pulse ends it three edges after clear is first sampled low.
- R7: If the falling trigger is high or the rising trigger is low, no edge starts a pulse: a rising-trigger edge with the falling trigger high does nothing, and so does a falling-trigger edge with the rising trigger low. A pulse already running continues unchanged when such a level appears.
- R8: While clear is low, the channel is armed if at any time the falling trigger is high or the rising trigger is low. If it is armed, and the falling trigger is low and the rising trigger high when clear rises, the release starts a pulse.
- R9: Releasing clear without that arming (falling trigger low and rising trigger high for the whole time clear was low) starts no pulse.
- R10: A trigger edge that arrives in the same cycle as clear going low starts no pulse.
- R11: Qn is always the complement of Q.
- R12: The two channels are independent. Triggering, clearing or timing one channel has no effect on the other.
- R13: In reset, Q is low and Qn high. The synchronised view resets to falling trigger high, rising trigger low and clear high, so inputs held at those levels cause no pulse on reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_fall_i | input | NUM_CH | Falling-edge trigger input, one per channel |
| trig_rise_i | input | NUM_CH | Rising-edge trigger input, one per channel |
| clr_n_i | input | NUM_CH | Active-low overriding clear, one per channel |
| width_i | input | NUM_CH*WIDTH | Pulse length in cycles, channel ch at [ch*WIDTH +: WIDTH] |
| pulse_o | output | NUM_CH | Active-high pulse output Q |
| pulse_n_o | output | NUM_CH | Complementary output Qn |

## Verification
The hardest state to reach from the ports is the pulse that clear release starts, because it depends on an arming history that builds up while clear is low and is never visible on an output. The bench walks every combination of trigger levels at three points: when clear falls, in the middle of the low period, and just before release. For each case it predicts from that history whether the release must fire. The bench also sweeps all sixteen before and after trigger-level pairs with clear high, and it checks truncation and the ignoring of retriggers by counting the pulse cycles.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Levels of one channel's three asynchronous inputs.
    typedef struct packed {
        logic fall_in;   // falling-edge trigger
        logic rise_in;   // rising-edge trigger
        logic clr_n;     // active-low clear
    } os_pins_t;

    // Quiescent levels: no edge is seen if inputs rest here at reset release.
    localparam os_pins_t PINS_IDLE = '{fall_in: 1'b1, rise_in: 1'b0, clr_n: 1'b1};

    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_FALL    = 2'd1,
        SRC_RISE    = 2'd2,
        SRC_RELEASE = 2'd3
    } os_src_e;

endpackage

// File: rtl/os_sync.sv
module os_sync
    import oneshot_pkg::*;
#(
    parameter int       STAGES  = 2,
    parameter os_pins_t RST_VAL = PINS_IDLE
) (
    input  logic     clk,
    input  logic     rst_n,
    input  os_pins_t pins_i,
    output os_pins_t pins_o
);

    typedef struct packed {
        os_pins_t [STAGES-1:0] stage;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d          = state_q;
        state_d.stage[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            state_d.stage[i] = state_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.stage <= {STAGES{RST_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign pins_o = state_q.stage[STAGES-1];

endmodule

// File: rtl/os_qualify.sv
module os_qualify
    import oneshot_pkg::*;
(
    input  os_pins_t cur_i,
    input  os_pins_t prev_i,
    input  logic     armed_i,
    output os_src_e  src_o,
    output logic     armed_o
);

    logic fall_edge;
    logic rise_edge;
    logic clr_edge;
    logic level_ok;

    always_comb begin
        fall_edge = prev_i.fall_in & ~cur_i.fall_in;
        rise_edge = ~prev_i.rise_in & cur_i.rise_in;
        clr_edge  = ~prev_i.clr_n & cur_i.clr_n;
        // Every start path needs the falling trigger low and the rising trigger high.
        level_ok  = ~cur_i.fall_in & cur_i.rise_in;

        src_o = SRC_NONE;
        if (cur_i.clr_n && level_ok) begin
            if (fall_edge) begin
                src_o = SRC_FALL;
            end else if (rise_edge) begin
                src_o = SRC_RISE;
            end else if (clr_edge && armed_i) begin
                src_o = SRC_RELEASE;
            end
        end

        // Arming accumulates only while clear is low; clear high drops it.
        if (cur_i.clr_n) begin
            armed_o = 1'b0;
        end else begin
            armed_o = armed_i | cur_i.fall_in | ~cur_i.rise_in;
        end
    end

endmodule

// File: rtl/os_channel.sv
module os_channel
    import oneshot_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  os_pins_t         pins_i,
    input  logic [WIDTH-1:0] width_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    localparam logic [WIDTH-1:0] CNT_ZERO = '0;
    localparam logic [WIDTH-1:0] CNT_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        os_pins_t         prev;
        logic             armed;
        logic [WIDTH-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    os_pins_t  synced;
    os_src_e   src;
    logic      armed_nxt;

    os_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .pins_o (synced)
    );

    os_qualify i_qualify (
        .cur_i   (synced),
        .prev_i  (st_q.prev),
        .armed_i (st_q.armed),
        .src_o   (src),
        .armed_o (armed_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.prev  = synced;
        st_d.armed = armed_nxt;
        if (!synced.clr_n) begin
            st_d.cnt = CNT_ZERO;
        end else if (st_q.cnt != CNT_ZERO) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
        end else if (src != SRC_NONE && width_i != CNT_ZERO) begin
            st_d.cnt = width_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= PINS_IDLE;
            st_q.armed <= 1'b0;
            st_q.cnt   <= CNT_ZERO;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o   = (st_q.cnt != CNT_ZERO);
    assign pulse_n_o = ~pulse_o;

endmodule

// File: rtl/oneshot_pair.sv
module oneshot_pair
    import oneshot_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       trig_fall_i,
    input  logic [NUM_CH-1:0]       trig_rise_i,
    input  logic [NUM_CH-1:0]       clr_n_i,
    input  logic [NUM_CH*WIDTH-1:0] width_i,
    output logic [NUM_CH-1:0]       pulse_o,
    output logic [NUM_CH-1:0]       pulse_n_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        os_pins_t pins;

        always_comb begin
            pins.fall_in = trig_fall_i[g];
            pins.rise_in = trig_rise_i[g];
            pins.clr_n   = clr_n_i[g];
        end

        os_channel #(
            .WIDTH       (WIDTH),
            .SYNC_STAGES (SYNC_STAGES)
        ) i_channel (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_i    (pins),
            .width_i   (width_i[g*WIDTH +: WIDTH]),
            .pulse_o   (pulse_o[g]),
            .pulse_n_o (pulse_n_o[g])
        );
    end

endmodule

// File: rtl/oneshot_pair_chk.sv
module oneshot_pair_chk #(
    parameter int NUM_CH = 2,
    parameter int WIDTH  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       clr_n_i,
    input logic [NUM_CH*WIDTH-1:0] width_i,
    input logic [NUM_CH-1:0]       pulse_o,
    input logic [NUM_CH-1:0]       pulse_n_o
);

    logic [1:0] warm_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assign ready = (warm_q == 2'd3);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic [WIDTH:0]   run_q;
        logic [WIDTH-1:0] wid_q;
        logic [WIDTH-1:0] wprev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q   <= '0;
                wid_q   <= '0;
                wprev_q <= '0;
            end else begin
                wprev_q <= width_i[g*WIDTH +: WIDTH];
                if (!pulse_o[g]) begin
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                    if (run_q == '0) begin
                        wid_q <= wprev_q;
                    end
                end
            end
        end

        // R6
        clr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && !$past(clr_n_i[g], 3)) |-> (!pulse_o[g] && pulse_n_o[g]));

        // R10
        start_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $rose(pulse_o[g])) |-> $past(clr_n_i[g], 3));

        // R4
        zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_o[g] && run_q == '0) |-> (wprev_q != '0));

        // R5
        no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_o[g] && run_q != '0) |-> (run_q < {1'b0, wid_q}));
    end

endmodule

bind oneshot_pair oneshot_pair_chk #(
    .NUM_CH (NUM_CH),
    .WIDTH  (WIDTH)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n_i   (clr_n_i),
    .width_i   (width_i),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o)
);

// File: tb/test_oneshot_pair.sv
`timescale 1ns/1ps
module test_oneshot_pair;

    localparam int NCH = 2;
    localparam int W   = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   a_r, b_r, c_r;
    logic [W-1:0]     w_r [NCH];
    logic [NCH*W-1:0] width_flat;
    logic [NCH-1:0]   pulse_o, pulse_n_o;

    int tests = 0;
    int fails = 0;
    int cpl_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) width_flat[i*W +: W] = w_r[i];
    end

    oneshot_pair #(.NUM_CH(NCH), .WIDTH(W)) i_oneshot_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fall_i (a_r),
        .trig_rise_i (b_r),
        .clr_n_i     (c_r),
        .width_i     (width_flat),
        .pulse_o     (pulse_o),
        .pulse_n_o   (pulse_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pins(input int ch, input logic a, input logic b, input logic c);
        a_r[ch] = a;
        b_r[ch] = b;
        c_r[ch] = c;
    endtask

    task automatic settle(input int ch);
        int guard = 0;
        repeat (4) @(negedge clk);
        while (pulse_o[ch] && guard < 600) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // Called at the negedge where the stimulus was driven.
    task automatic measure(input int ch, output int len);
        repeat (3) @(posedge clk);
        @(negedge clk);
        len = 0;
        while (pulse_o[ch] === 1'b1 && len < 600) begin
            if (pulse_n_o[ch] !== 1'b0) cpl_err++;
            len++;
            @(negedge clk);
        end
        if (pulse_n_o[ch] !== 1'b1) cpl_err++;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int len;
        int exp;
        int widths [6] = '{1, 2, 3, 7, 100, 255};

        rst_n = 1'b0;
        a_r = '1; b_r = '0; c_r = '1;
        for (int i = 0; i < NCH; i++) w_r[i] = '0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check(pulse_o == '0 && pulse_n_o == '1, "R13 reset outputs", int'(pulse_o), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(pulse_o == '0 && pulse_n_o == '1, "R13 no pulse after reset release", int'(pulse_o), 0);

        // R1 R2 R3: widths sweep for both trigger paths on both channels
        for (int ch = 0; ch < NCH; ch++) begin
            foreach (widths[k]) begin
                w_r[ch] = W'(widths[k]);
                set_pins(ch, 1'b1, 1'b1, 1'b1);
                settle(ch);
                a_r[ch] = 1'b0;
                measure(ch, len);
                check(len == widths[k], $sformatf("R1 R3 fall trigger ch%0d", ch), len, widths[k]);
                set_pins(ch, 1'b0, 1'b0, 1'b1);
                settle(ch);
                b_r[ch] = 1'b1;
                measure(ch, len);
                check(len == widths[k], $sformatf("R2 R3 rise trigger ch%0d", ch), len, widths[k]);
            end
        end

        // R7: all before/after level pairs with clear high
        for (int ch = 0; ch < NCH; ch++) begin
            w_r[ch] = W'(3);
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 4; n++) begin
                    logic pa, pb, na, nb;
                    pa = p[1]; pb = p[0]; na = n[1]; nb = n[0];
                    set_pins(ch, pa, pb, 1'b1);
                    settle(ch);
                    set_pins(ch, na, nb, 1'b1);
                    measure(ch, len);
                    exp = ((pa && !na && nb) || (!pb && nb && !na)) ? 3 : 0;
                    check(len == exp, $sformatf("R7 R1 R2 levels ch%0d %0d->%0d", ch, p, n), len, exp);
                end
            end
        end

        // R4: zero width
        w_r[0] = '0;
        set_pins(0, 1'b1, 1'b1, 1'b1);
        settle(0);
        a_r[0] = 1'b0;
        measure(0, len);
        repeat (5) @(negedge clk);
        check(len == 0 && pulse_o[0] == 1'b0, "R4 zero width", len, 0);

        // R5: retriggers ignored during pulse, nothing queued
        w_r[0] = W'(20);
        set_pins(0, 1'b1, 1'b1, 1'b1);
        settle(0);
        a_r[0] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        len = 0;
        while (pulse_o[0] && len < 600) begin
            len++;
            case (len)
                2:  a_r[0] = 1'b1;
                4:  a_r[0] = 1'b0;
                6:  b_r[0] = 1'b0;
                8:  b_r[0] = 1'b1;
                10: a_r[0] = 1'b1;
                12: a_r[0] = 1'b0;
                default: ;
            endcase
            @(negedge clk);
        end
        check(len == 20, "R5 R7 pulse length unaffected by retriggers", len, 20);
        exp = 0;
        for (int i = 0; i < 10; i++) begin
            if (pulse_o[0]) exp++;
            @(negedge clk);
        end
        check(exp == 0, "R5 no queued pulse", exp, 0);

        // R6: clear truncates, then R9 release without arming
        w_r[1] = W'(40);
        set_pins(1, 1'b1, 1'b1, 1'b1);
        settle(1);
        a_r[1] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        len = 0;
        while (pulse_o[1] && len < 600) begin
            len++;
            if (len == 10) c_r[1] = 1'b0;
            @(negedge clk);
        end
        check(len == 12, "R6 clear truncates pulse", len, 12);
        repeat (5) @(negedge clk);
        check(pulse_o[1] == 1'b0 && pulse_n_o[1] == 1'b1, "R6 outputs held during clear", int'(pulse_o[1]), 0);
        c_r[1] = 1'b1;
        measure(1, len);
        check(len == 0, "R9 release without arming", len, 0);

        // R10: edge together with clear falling
        w_r[0] = W'(5);
        set_pins(0, 1'b1, 1'b1, 1'b1);
        settle(0);
        a_r[0] = 1'b0;
        c_r[0] = 1'b0;
        measure(0, len);
        check(len == 0, "R10 clear wins same cycle", len, 0);
        repeat (3) @(negedge clk);
        c_r[0] = 1'b1;
        measure(0, len);
        check(len == 0, "R10 R9 later release", len, 0);

        // R8 R9: clear-release sweep over level history
        for (int ch = 0; ch < NCH; ch++) begin
            w_r[ch] = W'(2 + ch);
            for (int p = 0; p < 4; p++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int f = 0; f < 4; f++) begin
                        bit armed;
                        set_pins(ch, p[1], p[0], 1'b1);
                        settle(ch);
                        c_r[ch] = 1'b0;
                        repeat (4) @(negedge clk);
                        set_pins(ch, m[1], m[0], 1'b0);
                        repeat (4) @(negedge clk);
                        set_pins(ch, f[1], f[0], 1'b0);
                        repeat (4) @(negedge clk);
                        check(pulse_o[ch] == 1'b0, "R6 no pulse while clear low", int'(pulse_o[ch]), 0);
                        c_r[ch] = 1'b1;
                        measure(ch, len);
                        armed = p[1] || !p[0] || m[1] || !m[0];
                        exp = (!f[1] && f[0] && armed) ? 2 + ch : 0;
                        check(len == exp, $sformatf("R8 R9 release ch%0d %0d/%0d/%0d", ch, p, m, f), len, exp);
                    end
                end
            end
        end

        // R12: channels independent
        set_pins(1, 1'b1, 1'b0, 1'b1);
        w_r[0] = W'(6);
        set_pins(0, 1'b1, 1'b1, 1'b1);
        settle(0);
        settle(1);
        a_r[0] = 1'b0;
        c_r[1] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        len = 0;
        exp = 0;
        while (pulse_o[0] && len < 600) begin
            if (pulse_o[1]) exp++;
            len++;
            @(negedge clk);
        end
        check(len == 6, "R12 ch0 unaffected by ch1 clear", len, 6);
        check(exp == 0, "R12 ch1 quiet", exp, 0);
        c_r[1] = 1'b1;
        settle(1);

        // R11
        check(cpl_err == 0, "R11 complement output", cpl_err, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule